// File: doc/BRIEF.md
# Free-Running Timer with Two Compare Channels

This block is a 16-bit up-counter that never stops, together with two 16-bit compare channels, one overflow flag and a byte-wide register port for an 8-bit processor. A small phase counter divides the processor clock by 2, 4 or 8, as the control register selects. The main counter advances by one on each divided tick. When the counter steps onto a compare value, that channel raises its flag. It also loads a programmable level into an output latch, and a per-channel enable gates that latch onto a pin.

Software clears each flag in two steps. First it reads the status register while the flag is set. Then it accesses the low byte that belongs to the flag, by read or by write. The counter can also be reached at a second address pair. That pair returns the same count but never takes part in clearing the overflow flag, so code can sample time without losing a pending overflow. Reading a high byte freezes the matching low byte, so a pair of byte reads returns a consistent 16-bit value. Writing a compare high byte holds that channel's matching off until the low byte arrives.

Register addresses (4-bit): 0 control, 1 level select, 2 status, 3/4 counter high/low, 5/6 alias counter high/low, 7/8 compare A high/low, 9/10 compare B high/low. Any other address reads 0.

Top module: `fr_timer`

## Requirements
- R1: The counter resets to FFFCh. It increases by one on each prescaler tick, wraps from FFFFh to 0000h, and is otherwise stable.
- R2: Control bits 3:2 select the tick ratio: 00 gives every 4th clock, 01 every 2nd, 10 every 8th, and 11 behaves like 00. The phase counter restarts at reset, so with 00 the first increment happens on the 4th clock edge after reset.
- R3: The overflow flag (status bit 5) is set on the tick that wraps the counter to 0000h.
- R4: A status read made while the overflow flag is set, followed by a read or write of address 4, clears the flag. Accesses to address 6 leave it set. Writes to addresses 4 and 6 do not change the count.
- R5: Compare flag A (status bit 6) and flag B (status bit 3) are set on the tick that moves the counter onto the channel's compare value. Each is cleared by a status read and then a read or write of its own low byte (address 8 for A, address 10 for B).
- R6: A status read made while a flag is clear does not arm that flag. A low-byte access without an armed status read leaves the flag set. If a compare event falls in the same cycle as the clearing access, the flag stays set, and that access uses up the arming.
- R7: Pin A shows its output latch only while control bit 7 is 1, and pin B only while control bit 6 is 1. Otherwise the pin is 0. Flags are set whatever the enables are.
- R8: On each match, the channel's output latch loads the level-select bit for that channel (address 1: bit 0 for A, bit 1 for B). Changing the level-select bit between matches does not change the pin.
- R9: Control, level-select and status registers reset to 00h. Control reads back only bits 7, 6, 3 and 2, and level-select only bits 1:0. Writes to the status register are ignored.
- R10: Reading a counter high byte (address 3 or 5) latches the low byte of the same pair. The next low-byte read of that pair returns the latched value, and later low-byte reads return the live count.
- R11: After a compare high-byte write, that channel produces no match until its low byte is written.
- R12: Both compare registers reset to FFFFh and read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe for one cycle; side effects occur at the clock edge |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| cmp_a_pin | output | 1 | Gated output of compare channel A |
| cmp_b_pin | output | 1 | Gated output of compare channel B |

## Verification
The assertions assume that read and write strobes are never high together, and that each strobe lasts one clock. This way a status read and a clearing access can never fall in the same cycle. The bench drives each bus access from a task that raises exactly one strobe for one cycle and changes inputs only on the falling edge. Expected counts come from a cycle counter in the bench that is zeroed on each reset, so a match and a clearing access can be aimed at the same edge on purpose.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared widths, register addresses and field positions for the timer.
// Assumes a byte-wide bus and a counter twice the bus width.
package tmr_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int NUM_CMP = 2;
    localparam int PHASE_W = 3;

    localparam logic [CNT_W-1:0] CNT_INIT = 16'hFFFC;
    localparam logic [CNT_W-1:0] CMP_INIT = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        DIV4    = 2'b00,
        DIV2    = 2'b01,
        DIV8    = 2'b10,
        DIV_RSV = 2'b11
    } div_sel_e;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_LVL      = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT     = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd4;
    localparam logic [ADDR_W-1:0] A_ALT_HI   = 4'd5;
    localparam logic [ADDR_W-1:0] A_ALT_LO   = 4'd6;
    localparam int                A_CMP_BASE = 7;

    localparam int CTRL_PEN_TOP = 7;
    localparam int CTRL_DIV_LSB = 2;
    localparam int STAT_TOF     = 5;

    // Status bit position of each compare channel's flag.
    function automatic int ocf_bit(input int ch);
        return (ch == 0) ? 6 : 3;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Clock divider: a free-running phase counter whose low bits, chosen by
// div_sel, give a single-cycle tick. Assumes PHASE_W is 3.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e div_sel,
    output logic     tick
);
    logic [PHASE_W-1:0] phase_q;

    // Advance the phase every clock; restart on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // Decode the tick from the phase bits for the selected ratio.
    always_comb begin
        unique case (div_sel)
            DIV2:    tick = phase_q[0];
            DIV8:    tick = &phase_q;
            default: tick = &phase_q[1:0];
        endcase
    end

    // R2: ticks are never on adjacent cycles, at any ratio
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_evflag.sv
`timescale 1ns/1ps
// Event flag with a two-step clear: a status read arms the flag only if it
// is set, and the next qualifying access clears it unless a new event
// arrives in that same cycle. Assumes stat_rd and clr_acc never coincide.
module tmr_evflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag
);
    logic armed_q;

    // Arm on a status read that sees the flag set; disarm on the clearing access.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (stat_rd) armed_q <= flag;
        else if (clr_acc) armed_q <= 1'b0;
    end

    // Set on an event; clear on an armed access unless the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (set_evt)            flag <= 1'b1;
        else if (clr_acc && armed_q) flag <= 1'b0;
    end

    // R6: an event in any cycle leaves the flag set afterwards
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R6: a set flag cannot fall unless it was armed by a status read
    a_r6_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed_q) |=> flag);
endmodule

// File: rtl/tmr_rd_snap.sv
`timescale 1ns/1ps
// Low-byte snapshot for a 16-bit read pair: a high-byte read freezes the
// low byte until the next low-byte read. Assumes one read per cycle.
module tmr_rd_snap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_hi,
    input  logic          rd_lo,
    input  logic [DW-1:0] live_lo,
    output logic [DW-1:0] lo_out
);
    logic [DW-1:0] snap_q;
    logic          held_q;

    // Capture on a high read, release on the following low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            held_q <= 1'b0;
        end else if (rd_hi) begin
            snap_q <= live_lo;
            held_q <= 1'b1;
        end else if (rd_lo) begin
            held_q <= 1'b0;
        end
    end

    // Return the frozen byte while held, the live byte otherwise.
    assign lo_out = held_q ? snap_q : live_lo;

    // R10: a held snapshot does not move until released or re-captured
    a_r10_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !rd_hi) |=> $stable(snap_q));
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
// One compare channel: a byte-written compare value, a hold-off between
// the high and low writes, a match pulse on the tick that moves the counter
// onto the value, and an output latch loaded from a level bit on a match.
// Assumes W is twice DW and that wr_hi and wr_lo never coincide.
module tmr_cmp_chan #(
    parameter int DW = 8,
    parameter int W  = 16,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic [W-1:0]  cnt_next,
    input  logic          lvl_sel,
    output logic [W-1:0]  cmp_val,
    output logic          match,
    output logic          out_lvl
);
    logic inhibit_q;

    // Load the compare value one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_val <= INIT;
        else if (wr_hi) cmp_val[W-1:DW] <= wdata;
        else if (wr_lo) cmp_val[DW-1:0] <= wdata;
    end

    // Hold off matching from a high write until the low write.
    always_ff @(posedge clk) begin
        if (!rst_n)     inhibit_q <= 1'b0;
        else if (wr_hi) inhibit_q <= 1'b1;
        else if (wr_lo) inhibit_q <= 1'b0;
    end

    // Match when the counter is about to step onto the compare value.
    assign match = step && (cnt_next == cmp_val) && !inhibit_q;

    // Latch the programmed level on every match.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_lvl <= 1'b0;
        else if (match) out_lvl <= lvl_sel;
    end

    // R11: the cycle after a high-byte write cannot produce a match
    a_r11_hold_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !match);
    // R8: a match loads the level bit present at that edge
    a_r8_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (out_lvl == $past(lvl_sel)));
endmodule

// File: rtl/fr_timer.sv
`timescale 1ns/1ps
// Free-running timer top: byte register port, prescaled 16-bit counter with
// an alias read pair, compare channels, overflow and compare flags with a
// two-step clear, and enable-gated compare pins.
// Assumes bus_rd and bus_wr are never high in the same cycle.
module fr_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmp_a_pin,
    output logic              cmp_b_pin
);
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_next;
    logic               tick;
    div_sel_e           div_q;
    logic [NUM_CMP-1:0] pen_q;
    logic [NUM_CMP-1:0] lvl_q;
    logic [NUM_CMP-1:0] match;
    logic [NUM_CMP-1:0] out_lvl;
    logic [NUM_CMP-1:0] ocf;
    logic [CNT_W-1:0]   cmp_val [NUM_CMP];
    logic               tof;
    logic [DATA_W-1:0]  cnt_lo_rd;
    logic [DATA_W-1:0]  alt_lo_rd;
    logic [DATA_W-1:0]  stat_byte;

    logic any_acc;
    logic rd_stat, rd_cnt_hi, rd_cnt_lo, rd_alt_hi, rd_alt_lo;
    logic acc_cnt_lo, acc_alt_lo;

    // Decode the bus strobes per address.
    assign any_acc    = bus_rd | bus_wr;
    assign rd_stat    = bus_rd  && (bus_addr == A_STAT);
    assign rd_cnt_hi  = bus_rd  && (bus_addr == A_CNT_HI);
    assign rd_cnt_lo  = bus_rd  && (bus_addr == A_CNT_LO);
    assign rd_alt_hi  = bus_rd  && (bus_addr == A_ALT_HI);
    assign rd_alt_lo  = bus_rd  && (bus_addr == A_ALT_LO);
    assign acc_cnt_lo = any_acc && (bus_addr == A_CNT_LO);
    assign acc_alt_lo = any_acc && (bus_addr == A_ALT_LO);

    // Control and level-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q <= '0;
            lvl_q <= '0;
            div_q <= DIV4;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            for (int ch = 0; ch < NUM_CMP; ch++)
                pen_q[ch] <= bus_wdata[CTRL_PEN_TOP - ch];
            div_q <= div_sel_e'(bus_wdata[CTRL_DIV_LSB +: 2]);
        end else if (bus_wr && bus_addr == A_LVL) begin
            lvl_q <= bus_wdata[NUM_CMP-1:0];
        end
    end

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_q),
        .tick    (tick)
    );

    // Free-running counter, advanced by the prescaler tick.
    assign cnt_next = cnt_q + 1'b1;
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= CNT_INIT;
        else if (tick) cnt_q <= cnt_next;
    end

    tmr_evflag u_tof (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (tick && (&cnt_q)),
        .stat_rd (rd_stat),
        .clr_acc (acc_cnt_lo),
        .flag    (tof)
    );

    tmr_rd_snap #(.DW(DATA_W)) u_snap_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_cnt_hi),
        .rd_lo   (rd_cnt_lo),
        .live_lo (cnt_q[DATA_W-1:0]),
        .lo_out  (cnt_lo_rd)
    );

    tmr_rd_snap #(.DW(DATA_W)) u_snap_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_alt_hi),
        .rd_lo   (rd_alt_lo),
        .live_lo (cnt_q[DATA_W-1:0]),
        .lo_out  (alt_lo_rd)
    );

    // One compare channel, flag and pin per generated slice.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_CMP_BASE + 2 * g);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CMP_BASE + 2 * g + 1);

        tmr_cmp_chan #(.DW(DATA_W), .W(CNT_W), .INIT(CMP_INIT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hi    (bus_wr && bus_addr == HI_A),
            .wr_lo    (bus_wr && bus_addr == LO_A),
            .wdata    (bus_wdata),
            .step     (tick),
            .cnt_next (cnt_next),
            .lvl_sel  (lvl_q[g]),
            .cmp_val  (cmp_val[g]),
            .match    (match[g]),
            .out_lvl  (out_lvl[g])
        );

        tmr_evflag u_ocf (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (match[g]),
            .stat_rd (rd_stat),
            .clr_acc (any_acc && bus_addr == LO_A),
            .flag    (ocf[g])
        );
    end

    // Gate each compare output onto its pin.
    assign cmp_a_pin = pen_q[0] & out_lvl[0];
    assign cmp_b_pin = pen_q[1] & out_lvl[1];

    // Assemble the status byte from the flags.
    always_comb begin
        stat_byte           = '0;
        stat_byte[STAT_TOF] = tof;
        for (int ch = 0; ch < NUM_CMP; ch++)
            stat_byte[ocf_bit(ch)] = ocf[ch];
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                for (int ch = 0; ch < NUM_CMP; ch++)
                    bus_rdata[CTRL_PEN_TOP - ch] = pen_q[ch];
                bus_rdata[CTRL_DIV_LSB +: 2] = div_q;
            end
            A_LVL:    bus_rdata[NUM_CMP-1:0] = lvl_q;
            A_STAT:   bus_rdata = stat_byte;
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            A_CNT_LO: bus_rdata = cnt_lo_rd;
            A_ALT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            A_ALT_LO: bus_rdata = alt_lo_rd;
            default: begin
                for (int ch = 0; ch < NUM_CMP; ch++) begin
                    if (bus_addr == ADDR_W'(A_CMP_BASE + 2 * ch))
                        bus_rdata = cmp_val[ch][CNT_W-1:DATA_W];
                    if (bus_addr == ADDR_W'(A_CMP_BASE + 2 * ch + 1))
                        bus_rdata = cmp_val[ch][DATA_W-1:0];
                end
            end
        endcase
    end

    // R1: the counter steps by exactly one on a tick
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 16'd1));
    // R1: the counter holds between ticks
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R3: the wrap from all ones leaves the overflow flag set
    a_r3_tof_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == 16'hFFFF) |=> tof);
    // R4: alias low-byte accesses never clear the overflow flag
    a_r4_alt_keeps_tof: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_alt_lo && tof) |=> tof);
endmodule

// File: tb/tb_fr_timer.sv
`timescale 1ns/1ps
// Directed bench for fr_timer: one task per scenario, each checking itself.
module tb_fr_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_a_pin, cmp_b_pin;

    int unsigned ncyc;
    int nvec = 0;
    int nbad = 0;

    fr_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_a_pin (cmp_a_pin),
        .cmp_b_pin (cmp_b_pin)
    );

    always #5 clk = ~clk;

    // Clock edges since reset release; with ratio /4 the count is FFFC + n/4.
    always @(posedge clk) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= ncyc + 1;
    end

    function automatic logic [15:0] exp_cnt(input int unsigned n);
        return 16'hFFFC + 16'(n / 4);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {8'h00, d}, {8'h00, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic wait_until(input int unsigned n);
        while (ncyc < n) begin @(posedge clk); #1; end
    endtask

    // R9, R12: reset values, reserved bits, read-only status
    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R9 pin A at reset", {15'd0, cmp_a_pin}, 16'd0);
        chk("R9 pin B at reset", {15'd0, cmp_b_pin}, 16'd0);
        rd_chk("R9 ctrl reset", 4'd0, 8'h00);
        rd_chk("R9 level reset", 4'd1, 8'h00);
        rd_chk("R9 status reset", 4'd2, 8'h00);
        rd_chk("R12 cmp A hi reset", 4'd7, 8'hFF);
        rd_chk("R12 cmp B lo reset", 4'd10, 8'hFF);
        wr(4'd0, 8'hFF);
        rd_chk("R9 ctrl reserved bits", 4'd0, 8'hCC);
        wr(4'd1, 8'hFF);
        rd_chk("R9 level reserved bits", 4'd1, 8'h03);
        wr(4'd2, 8'hFF);
        rd_chk("R9 status ignores write", 4'd2, 8'h00);
        wr(4'd9, 8'h12); wr(4'd10, 8'h34);
        rd_chk("R12 cmp B hi readback", 4'd9, 8'h12);
        rd_chk("R12 cmp B lo readback", 4'd10, 8'h34);
    endtask

    // R2: measure the clocks between counter changes for each ratio code
    task automatic t_ratios();
        logic [7:0] prev, cur;
        int first, second, expv;
        for (int s = 0; s < 4; s++) begin
            do_reset();
            wr(4'd0, 8'(s << 2));
            wr(4'd4, 8'hAA);
            first = -1; second = -1;
            rd(4'd4, prev);
            for (int i = 0; i < 40; i++) begin
                rd(4'd4, cur);
                if (cur != prev) begin
                    if (first < 0) first = i;
                    else if (second < 0) second = i;
                end
                prev = cur;
            end
            expv = (s == 1) ? 2 : (s == 2) ? 8 : 4;
            chk($sformatf("R2 ratio code %0d", s), 16'(second - first), 16'(expv));
        end
    endtask

    // R10, R1: counter value, high-read snapshot on both pairs
    task automatic t_latch();
        logic [7:0] d;
        logic [15:0] e;
        do_reset();
        wait_until(30);
        @(negedge clk);
        bus_addr = 4'd3; bus_rd = 1'b1;
        #1 d = bus_rdata; e = exp_cnt(ncyc);
        @(posedge clk); #1 bus_rd = 1'b0;
        chk("R1 counter high byte", {8'h00, d}, {8'h00, e[15:8]});
        repeat (25) @(posedge clk);
        rd_chk("R10 main low latched", 4'd4, e[7:0]);
        @(negedge clk);
        bus_addr = 4'd4; bus_rd = 1'b1;
        #1 d = bus_rdata; e = exp_cnt(ncyc);
        @(posedge clk); #1 bus_rd = 1'b0;
        chk("R1 R10 main low live", {8'h00, d}, {8'h00, e[7:0]});
        @(negedge clk);
        bus_addr = 4'd5; bus_rd = 1'b1;
        #1 e = exp_cnt(ncyc);
        @(posedge clk); #1 bus_rd = 1'b0;
        repeat (13) @(posedge clk);
        rd_chk("R10 alias low latched", 4'd6, e[7:0]);
    endtask

    // R3, R4, R5: overflow set on wrap, alias accesses ignored, clears
    task automatic t_tof();
        do_reset();
        wait_until(20);
        rd_chk("R3 R5 flags after wrap", 4'd2, 8'h68);
        rd_chk("R4 alias low read", 4'd6, exp_cnt(ncyc + 1)[7:0]);
        wr(4'd6, 8'h00);
        rd_chk("R4 alias access keeps overflow", 4'd2, 8'h68);
        wr(4'd4, 8'h55);
        rd_chk("R4 overflow cleared by main low", 4'd2, 8'h48);
        rd_chk("R4 counter write ignored", 4'd4, exp_cnt(ncyc + 1)[7:0]);
        rd_chk("R5 cmp A lo read", 4'd8, 8'hFF);
        rd_chk("R5 cmp B lo read", 4'd10, 8'hFF);
        rd_chk("R5 compare flags cleared", 4'd2, 8'h00);
    endtask

    // R6: no arming without a set flag at the status read
    task automatic t_no_arm();
        do_reset();
        wait_until(20);
        rd_chk("R6 counter low read", 4'd4, exp_cnt(ncyc + 1)[7:0]);
        rd_chk("R6 unarmed access keeps flags", 4'd2, 8'h68);
        rd_chk("R6 cmp A lo", 4'd8, 8'hFF);
        rd_chk("R6 A cleared when armed", 4'd2, 8'h28);
        wr(4'd7, 8'h00); wr(4'd8, 8'h20);
        wait_until(150);
        rd_chk("R6 cmp A lo after match", 4'd8, 8'h20);
        rd_chk("R6 clear-state status read did not arm", 4'd2, 8'h68);
    endtask

    // R6, R5: a match at the clearing edge keeps the flag
    task automatic t_same_cycle();
        do_reset();
        wait_until(14);
        wr(4'd7, 8'h00); wr(4'd8, 8'h10);
        rd_chk("R5 flags before arm", 4'd2, 8'h68);
        wait_until(79);
        rd_chk("R6 cmp A lo at match edge", 4'd8, 8'h10);
        rd_chk("R6 event beats clear", 4'd2, 8'h68);
        rd_chk("R5 cmp A lo clear", 4'd8, 8'h10);
        rd_chk("R5 cmp A flag cleared", 4'd2, 8'h28);
    endtask

    // R7, R8: pin gating and level loading on a match
    task automatic t_pins();
        do_reset();
        wr(4'd1, 8'h03);
        wr(4'd0, 8'h80);
        chk("R7 pin A before match", {15'd0, cmp_a_pin}, 16'd0);
        wait_until(14);
        chk("R8 pin A after match", {15'd0, cmp_a_pin}, 16'd1);
        chk("R7 pin B disabled", {15'd0, cmp_b_pin}, 16'd0);
        rd_chk("R7 flag B set while pin disabled", 4'd2, 8'h48);
        wr(4'd0, 8'hC0);
        chk("R7 pin B enabled", {15'd0, cmp_b_pin}, 16'd1);
        wr(4'd1, 8'h00);
        wr(4'd7, 8'h00); wr(4'd8, 8'h05);
        chk("R8 level change alone keeps pin", {15'd0, cmp_a_pin}, 16'd1);
        wait_until(37);
        chk("R8 pin A reloaded", {15'd0, cmp_a_pin}, 16'd0);
        chk("R8 pin B unchanged", {15'd0, cmp_b_pin}, 16'd1);
        wr(4'd0, 8'h00);
        chk("R7 pin B gated off", {15'd0, cmp_b_pin}, 16'd0);
    endtask

    // R11: high write holds matching off until the low write
    task automatic t_inhibit();
        do_reset();
        wait_until(20);
        rd_chk("R11 flags", 4'd2, 8'h68);
        rd_chk("R11 clear A", 4'd8, 8'hFF);
        wr(4'd7, 8'h00);
        wait_until(1044);
        rd_chk("R11 no match while held", 4'd2, 8'h28);
        wr(4'd7, 8'h01); wr(4'd8, 8'h40);
        wait_until(1300);
        rd_chk("R11 match after low write", 4'd2, 8'h68);
        rd_chk("R11 cmp A hi", 4'd7, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ratios();
        t_latch();
        t_tof();
        t_no_arm();
        t_same_cycle();
        t_pins();
        t_inhibit();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule